// File: doc/BRIEF.md
# Oscillator-Fail Monitor with Shared Interrupt / General Output Pin

This block keeps the oscillator-fail flag of a timekeeping core and computes the level requested on one shared open-drain pin. The flag comes up set after reset and is set again whenever the oscillator is seen halted or software holds the stop bit. Software can clear it only with an explicit write of 0. Reading it has no side effect. A clear is accepted only after the oscillator has run long enough to prove that it has restarted. The proof is a count of one-second ticks seen while the oscillator was running without interruption.

The pin has two modes. If any interrupt source is enabled (oscillator-fail, alarm or watchdog), the pin becomes an active-low interrupt line. It pulls low while any enabled request is pending. If no source is enabled, the pin becomes a general output that follows a software bit. The output `pin_pull_n` is a pull-down request: 0 means the pad must pull low and 1 means the pad must release. The fail-interrupt enable and the software output bit are held in a small control register inside the block. The alarm and watchdog enables and their requests come from neighbouring blocks as levels.

Top module: `osc_irq_monitor`

## Requirements
- R1: During and right after reset, `osc_fail` is 1, the fail-interrupt enable is 0, the output bit is 1, and `pin_pull_n` is 1.
- R2: If `osc_halted` or `stop_bit` is 1 during a cycle, `osc_fail` is 1 after that clock edge and stays 1 once the cause goes away.
- R3: `osc_fail` changes from 1 to 0 only through an accepted write of 0 (`flag_wr`=1, `flag_wdata`=0). With no write, the value it had is kept.
- R4: A write of 0 is ignored unless SETTLE_TICKS (default 2) `sec_tick` pulses have been seen, while running, in earlier cycles since `osc_halted` and `stop_bit` were last 1. A tick in the same cycle as the write does not count.
- R5: If a halt or stop and a write of 0 fall in the same cycle, the flag ends up 1.
- R6: A write of 1 to the flag (`flag_wr`=1, `flag_wdata`=1) sets it.
- R7: The pin is in interrupt mode when the fail-interrupt enable, `alarm_ie` or `wdog_en` is 1. In interrupt mode, `pin_pull_n` is 0 exactly when (fail enable AND `osc_fail`) OR (`alarm_ie` AND `alarm_flag`) OR (`wdog_en` AND `wdog_irq`). The output bit has no effect in this mode.
- R8: A fail interrupt is released by clearing the flag or by clearing the fail-interrupt enable. If no other request is active, `pin_pull_n` goes back to 1.
- R9: In general-output mode, `pin_pull_n` equals the stored output bit. `osc_fail`, `alarm_flag` and `wdog_irq` have no effect in this mode.
- R10: A `ctl_wr` pulse loads `ctl_wdata` at the clock edge: bit 1 is the fail-interrupt enable and bit 0 is the output bit. `pin_pull_n` reflects the new value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| osc_halted | input | 1 | Oscillator seen stopped |
| stop_bit | input | 1 | Software stop bit level |
| sec_tick | input | 1 | One-cycle pulse per second from the running oscillator |
| flag_wr | input | 1 | Write strobe for the fail flag |
| flag_wdata | input | 1 | Value written to the fail flag |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 2 | [1] fail-interrupt enable, [0] output bit |
| alarm_ie | input | 1 | Alarm interrupt enable |
| alarm_flag | input | 1 | Alarm request |
| wdog_en | input | 1 | Watchdog armed |
| wdog_irq | input | 1 | Watchdog time-out request |
| osc_fail | output | 1 | Oscillator-fail flag |
| pin_pull_n | output | 1 | Pin request: 0 means pull low, 1 means release |

## Verification
Two events can collide in the same cycle: a software write of 0 to the fail flag and a new halt or stop indication. The bench drives both in one cycle and expects the flag to stay set, with the pin still pulled low while the fail interrupt is enabled. The bench also places a write of 0 one tick short of the settle count, and directly after a stop-bit restart, and expects the flag to be unchanged both times. A scoreboard states, for every cycle, the expected flag and pin levels and compares them against the outputs one edge later.

// File: rtl/oscmon_pkg.sv
package oscmon_pkg;

    typedef enum logic {
        PIN_GPO = 1'b0,
        PIN_IRQ = 1'b1
    } pin_mode_e;

    typedef struct packed {
        logic fail_ie;
        logic out_lvl;
    } ctl_s;

    typedef struct packed {
        logic fail;
        logic alarm;
        logic wdog;
    } req_s;

    localparam int CTL_W = 2;
    localparam ctl_s CTL_RESET = '{fail_ie: 1'b0, out_lvl: 1'b1};

    function automatic ctl_s ctl_unpack(input logic [CTL_W-1:0] bits);
        ctl_s c;
        c.fail_ie = bits[1];
        c.out_lvl = bits[0];
        return c;
    endfunction

    function automatic logic req_any(input req_s r);
        return r.fail | r.alarm | r.wdog;
    endfunction

endpackage

// File: rtl/oscmon_settle.sv
module oscmon_settle #(
    parameter int SETTLE_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_any,
    input  logic sec_tick,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] CMAX = CW'(SETTLE_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (halt_any) begin
            cnt_q <= '0;
        end else if (sec_tick && (cnt_q != CMAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign settled = (cnt_q == CMAX);

    // R4: a halt or stop throws away any running proof
    a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
        halt_any |=> !settled);

endmodule

// File: rtl/oscmon_flag.sv
module oscmon_flag (
    input  logic clk,
    input  logic rst,
    input  logic halt_any,
    input  logic wr_en,
    input  logic wr_val,
    input  logic settled,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b1;
        end else if (halt_any) begin
            flag_q <= 1'b1;
        end else if (wr_en && wr_val) begin
            flag_q <= 1'b1;
        end else if (wr_en && settled) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

    a_r2_set_on_halt: assert property (@(posedge clk) disable iff (rst)
        halt_any |=> flag_q);

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !wr_en) |=> flag_q);

    a_r4_no_early_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_q && wr_en && !settled) |=> flag_q);

endmodule

// File: rtl/oscmon_pin.sv
module oscmon_pin
    import oscmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_s ctl,
    input  logic fail_flag,
    input  logic alarm_ie,
    input  logic alarm_flag,
    input  logic wdog_en,
    input  logic wdog_irq,
    output logic pin_pull_n
);
    pin_mode_e mode;
    req_s      req;

    always_comb begin
        mode = (ctl.fail_ie || alarm_ie || wdog_en) ? PIN_IRQ : PIN_GPO;
        req.fail  = ctl.fail_ie & fail_flag;
        req.alarm = alarm_ie & alarm_flag;
        req.wdog  = wdog_en & wdog_irq;
        if (mode == PIN_IRQ) begin
            pin_pull_n = ~req_any(req);
        end else begin
            pin_pull_n = ctl.out_lvl;
        end
    end

    // R7: an enabled fail flag pulls the pin low
    a_r7_fail_pulls: assert property (@(posedge clk) disable iff (rst)
        (ctl.fail_ie && fail_flag) |-> !pin_pull_n);

    // R9: with every source disabled, the pin mirrors the output bit
    a_r9_follow_out: assert property (@(posedge clk) disable iff (rst)
        (!ctl.fail_ie && !alarm_ie && !wdog_en) |-> (pin_pull_n == ctl.out_lvl));

endmodule

// File: rtl/osc_irq_monitor.sv
module osc_irq_monitor
    import oscmon_pkg::*;
#(
    parameter int SETTLE_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_halted,
    input  logic       stop_bit,
    input  logic       sec_tick,
    input  logic       flag_wr,
    input  logic       flag_wdata,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_wdata,
    input  logic       alarm_ie,
    input  logic       alarm_flag,
    input  logic       wdog_en,
    input  logic       wdog_irq,
    output logic       osc_fail,
    output logic       pin_pull_n
);
    logic halt_any;
    logic settled;
    ctl_s ctl_q;

    assign halt_any = osc_halted | stop_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_wr) begin
            ctl_q <= ctl_unpack(ctl_wdata);
        end
    end

    oscmon_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .halt_any (halt_any),
        .sec_tick (sec_tick),
        .settled  (settled)
    );

    oscmon_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .halt_any (halt_any),
        .wr_en    (flag_wr),
        .wr_val   (flag_wdata),
        .settled  (settled),
        .flag     (osc_fail)
    );

    oscmon_pin u_pin (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl_q),
        .fail_flag  (osc_fail),
        .alarm_ie   (alarm_ie),
        .alarm_flag (alarm_flag),
        .wdog_en    (wdog_en),
        .wdog_irq   (wdog_irq),
        .pin_pull_n (pin_pull_n)
    );

    // R10: a control write lands at the next edge
    a_r10_ctl_load: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_q == ctl_unpack($past(ctl_wdata))));

    // R5: set beats a simultaneous clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (halt_any && flag_wr && !flag_wdata) |=> osc_fail);

endmodule

// File: tb/osc_irq_monitor_bench.sv
module osc_irq_monitor_bench;

    typedef struct {
        int    due;
        bit    is_pin;
        logic  val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_halted = 1'b0, stop_bit = 1'b0, sec_tick = 1'b0;
    logic       flag_wr = 1'b0, flag_wdata = 1'b0, ctl_wr = 1'b0;
    logic [1:0] ctl_wdata = 2'b00;
    logic       alarm_ie = 1'b0, alarm_flag = 1'b0, wdog_en = 1'b0, wdog_irq = 1'b0;
    logic       osc_fail, pin_pull_n;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    osc_irq_monitor u_osc_irq_monitor (
        .clk(clk), .rst(rst), .osc_halted(osc_halted), .stop_bit(stop_bit),
        .sec_tick(sec_tick), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .alarm_ie(alarm_ie),
        .alarm_flag(alarm_flag), .wdog_en(wdog_en), .wdog_irq(wdog_irq),
        .osc_fail(osc_fail), .pin_pull_n(pin_pull_n)
    );

    task automatic chk(input logic act, input logic expv, input string tag);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, expv);
        end
    endtask

    // driver: queue expectations for the edge after this one, then advance
    task automatic step(input logic ef, input logic ep, input string tag);
        exp_q.push_back('{due: cyc + 1, is_pin: 1'b0, val: ef, tag: {tag, " flag"}});
        exp_q.push_back('{due: cyc + 1, is_pin: 1'b1, val: ep, tag: {tag, " pin"}});
        @(negedge clk);
        flag_wr  = 1'b0;
        ctl_wr   = 1'b0;
        sec_tick = 1'b0;
    endtask

    // monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
                exp_t it;
                logic act;
                it  = exp_q.pop_front();
                act = it.is_pin ? pin_pull_n : osc_fail;
                n_run++;
                if (it.due != cyc || act !== it.val) begin
                    n_fail++;
                    $display("FAIL %s actual=%b expected=%b (cycle %0d due %0d)",
                             it.tag, act, it.val, cyc, it.due);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: all requirements actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(osc_fail, 1'b1, "R1 flag in reset");
        chk(pin_pull_n, 1'b1, "R1 pin in reset");
        rst = 1'b0;
        step(1, 1, "R1 idle after reset");

        ctl_wr = 1; ctl_wdata = 2'b00; step(1, 0, "R10 R9 out bit low");
        step(1, 0, "R9 out bit held");
        ctl_wr = 1; ctl_wdata = 2'b01; step(1, 1, "R10 R9 out bit high");

        flag_wr = 1; flag_wdata = 0; step(1, 1, "R4 clear with no tick");
        sec_tick = 1; step(1, 1, "R4 first tick");
        flag_wr = 1; flag_wdata = 0; sec_tick = 1; step(1, 1, "R4 same-cycle tick not counted");
        flag_wr = 1; flag_wdata = 0; step(0, 1, "R3 clear after settle");
        for (int i = 0; i < 3; i++) step(0, 1, "R3 cleared flag holds");
        flag_wr = 1; flag_wdata = 1; step(1, 1, "R6 write one sets");
        flag_wr = 1; flag_wdata = 0; step(0, 1, "R3 clear again");

        ctl_wr = 1; ctl_wdata = 2'b11; step(0, 1, "R7 irq mode without request");
        stop_bit = 1; step(1, 0, "R2 stop bit sets flag");
        stop_bit = 0; step(1, 0, "R2 flag kept after stop");
        flag_wr = 1; flag_wdata = 0; step(1, 0, "R4 restart voids settle");
        sec_tick = 1; step(1, 0, "R4 tick one after restart");
        sec_tick = 1; step(1, 0, "R4 tick two after restart");
        flag_wr = 1; flag_wdata = 0; step(0, 1, "R8 release by clearing flag");

        osc_halted = 1; flag_wr = 1; flag_wdata = 0; step(1, 0, "R5 set wins over clear");
        osc_halted = 0; step(1, 0, "R2 flag kept after halt");
        ctl_wr = 1; ctl_wdata = 2'b01; step(1, 1, "R8 release by clearing enable");
        ctl_wr = 1; ctl_wdata = 2'b00; step(1, 0, "R9 flag ignored in output mode");

        alarm_ie = 1; step(1, 1, "R7 alarm enable masks out bit");
        alarm_flag = 1; step(1, 0, "R7 alarm request pulls");
        alarm_flag = 0; step(1, 1, "R7 alarm request gone");
        alarm_ie = 0; alarm_flag = 1; step(1, 0, "R9 alarm flag ignored when disabled");
        alarm_flag = 0;

        ctl_wr = 1; ctl_wdata = 2'b01; step(1, 1, "R10 out bit high again");
        wdog_irq = 1; step(1, 1, "R9 watchdog request ignored when disarmed");
        wdog_en = 1; step(1, 0, "R7 watchdog request pulls");
        wdog_irq = 0; step(1, 1, "R7 watchdog idle in irq mode");
        ctl_wr = 1; ctl_wdata = 2'b00; step(1, 1, "R7 out bit ignored in irq mode");
        wdog_en = 0; step(1, 0, "R9 back to output mode");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule